// File: doc/BRIEF.md
# Strobed Watchdog Timer with Selectable Period

This block watches a processor's liveness signal. Firmware services the timer by driving a strobe line from high to low. If no such falling edge arrives within the chosen period, the block raises a one-cycle timeout request. A separate reset generator turns that request into a system reset.

The period is measured in ticks of a 1 ms enable supplied from outside. A 2-bit select chooses one of three periods. The select is captured only when the count restarts.

The timer cannot be switched off. The strobe is synchronised and edge-detected on every clock, so a low pulse lasting a single clock is still seen. The reset generator reports its status on a reset-active input. While that input is high, the count is cleared and strobe activity has no effect.

Top module: `wd_strobe_watchdog`

## Requirements
- R1: While `rst` is high, `timeout_o` is 0. When `rst` is released with `rst_active_i` low, the count starts from zero.
- R2: A falling edge of `strobe_i` seen while running clears the count. The next timeout then follows exactly P ticks after that edge, where P is the latched period.
- R3: A rising edge of `strobe_i`, or a steady level, does not restart the count.
- R4: No enable exists. With no strobe at all, a timeout follows P ticks after `rst_active_i` falls.
- R5: `period_sel_i` picks the period: 00 gives P_SHORT (default 150), 01 gives P_MID (default 610), 10 gives P_LONG (default 1200), and 11 is handled like 01.
- R6: `period_sel_i` is captured only at a restart (a strobe edge, or while reset is active). A change in mid-count has no effect until the next restart.
- R7: While `rst_active_i` is high, no timeout is issued and strobe edges are ignored. After a timeout, strobe edges are also ignored until reset-active has been asserted.
- R8: A timeout is a single-cycle pulse. After it, the count stays at zero and no further pulse occurs until `rst_active_i` has been asserted and then released.
- R9: A strobe low for only one clock cycle is detected as a falling edge.
- R10: If a strobe edge and a tick are acted on in the same cycle, the restart wins and the count is zero afterwards.
- R11: The count advances only on cycles where `tick_ms_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms_i | input | 1 | One-cycle enable, once per millisecond |
| strobe_i | input | 1 | Asynchronous service strobe, idles high |
| period_sel_i | input | 2 | Period select code |
| rst_active_i | input | 1 | High while the system reset is being driven |
| timeout_o | output | 1 | One-cycle timeout request |

## Verification
The assertions assume that `tick_ms_i` is a single-cycle enable. They also assume that `rst_active_i` goes high some time after a timeout, as a reset generator would drive it.

The stimulus raises ticks for one cycle at a time, with idle cycles between them. It only ever asserts reset-active as a multi-cycle pulse.

Strobe edges are spaced several clocks apart, so each edge clears the two-flop synchroniser before the next one. The single exception is a test that deliberately lines up an edge with a tick.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [1:0] {
        SEL_SHORT = 2'b00,
        SEL_MID   = 2'b01,
        SEL_LONG  = 2'b10,
        SEL_ALIAS = 2'b11
    } wd_sel_e;

    typedef enum logic [1:0] {
        ST_HELD    = 2'b00,
        ST_RUN     = 2'b01,
        ST_EXPIRED = 2'b10
    } wd_state_e;

    typedef struct packed {
        logic load;
        logic restart;
    } wd_ctrl_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned pick_period(input wd_sel_e sel, input int unsigned ps,
                                                input int unsigned pm, input int unsigned pl);
        case (sel)
            SEL_SHORT: return ps;
            SEL_LONG:  return pl;
            default:   return pm;
        endcase
    endfunction

endpackage

// File: rtl/wd_strobe_edge.sv
module wd_strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic fall_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= strobe_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[LAST-1:0], strobe_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[LAST];
    end

    assign fall_o = prev_q & ~chain_q[LAST];

    // R9: a single-cycle edge indication for each falling edge
    a_r9_fall_isolated: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/wd_period_reg.sv
module wd_period_reg
    import wd_pkg::*;
#(
    parameter int unsigned P_SHORT = 150,
    parameter int unsigned P_MID   = 610,
    parameter int unsigned P_LONG  = 1200,
    parameter int          CNT_W   = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] limit_o
);
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] limit_d;

    always_comb begin
        limit_d = CNT_W'(pick_period(wd_sel_e'(sel_i), P_SHORT, P_MID, P_LONG));
    end

    always_ff @(posedge clk) begin
        if (rst)         limit_q <= CNT_W'(P_SHORT);
        else if (load_i) limit_q <= limit_d;
    end

    assign limit_o = limit_q;

    // R6: the period only changes on a restart
    a_r6_limit_hold: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(limit_q));

    // R5: the latched period is always one of the three settings
    a_r5_limit_legal: assert property (@(posedge clk) disable iff (rst)
        (limit_q == CNT_W'(P_SHORT)) || (limit_q == CNT_W'(P_MID)) ||
        (limit_q == CNT_W'(P_LONG)));

endmodule

// File: rtl/wd_core.sv
module wd_core
    import wd_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             fall_i,
    input  logic             rst_active_i,
    input  logic [CNT_W-1:0] limit_i,
    output wd_ctrl_t         ctrl_o,
    output logic             timeout_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wd_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             to_q;
    logic             last_tick;

    always_comb begin
        ctrl_o.restart = (state_q == ST_RUN) && fall_i && !rst_active_i;
        ctrl_o.load    = (state_q == ST_HELD) || ctrl_o.restart;
        last_tick      = (cnt_q == limit_i - ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HELD;
            cnt_q   <= '0;
            to_q    <= 1'b0;
        end else begin
            to_q <= 1'b0;
            unique case (state_q)
                ST_HELD: begin
                    cnt_q <= '0;
                    if (!rst_active_i) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (rst_active_i) begin
                        state_q <= ST_HELD;
                        cnt_q   <= '0;
                    end else if (ctrl_o.restart) begin
                        cnt_q <= '0;
                    end else if (tick_i) begin
                        if (last_tick) begin
                            cnt_q   <= '0;
                            to_q    <= 1'b1;
                            state_q <= ST_EXPIRED;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                end
                ST_EXPIRED: begin
                    cnt_q <= '0;
                    if (rst_active_i) state_q <= ST_HELD;
                end
                default: begin
                    state_q <= ST_HELD;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign timeout_o = to_q;

    // R1: reset clears the request and parks the timer
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!timeout_o && state_q == ST_HELD && cnt_q == '0));

    // R8: the request lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    // R8: after expiry the count stays cleared
    a_r8_hold_cleared: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (cnt_q == '0));

    // R7: no request while reset is active
    a_r7_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
        rst_active_i |=> !timeout_o);

    // R11: a request only follows a tick
    a_r11_tick_needed: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> $past(tick_i));

    // R2: the running count never reaches the period
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (cnt_q < limit_i));

    // R10: a restart leaves the count at zero even with a tick present
    a_r10_restart_wins: assert property (@(posedge clk) disable iff (rst)
        ctrl_o.restart |=> (cnt_q == '0));

endmodule

// File: rtl/wd_strobe_watchdog.sv
module wd_strobe_watchdog
    import wd_pkg::*;
#(
    parameter int unsigned P_SHORT     = 150,
    parameter int unsigned P_MID       = 610,
    parameter int unsigned P_LONG      = 1200,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_ms_i,
    input  logic       strobe_i,
    input  logic [1:0] period_sel_i,
    input  logic       rst_active_i,
    output logic       timeout_o
);
    localparam int unsigned P_MAX = max3(P_SHORT, P_MID, P_LONG);
    localparam int          CNT_W = $clog2(P_MAX + 1);

    logic             fall;
    logic [CNT_W-1:0] limit;
    wd_ctrl_t         ctrl;

    wd_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe_i),
        .fall_o   (fall)
    );

    wd_period_reg #(
        .P_SHORT (P_SHORT),
        .P_MID   (P_MID),
        .P_LONG  (P_LONG),
        .CNT_W   (CNT_W)
    ) u_period (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ctrl.load),
        .sel_i   (period_sel_i),
        .limit_o (limit)
    );

    wd_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_ms_i),
        .fall_i       (fall),
        .rst_active_i (rst_active_i),
        .limit_i      (limit),
        .ctrl_o       (ctrl),
        .timeout_o    (timeout_o)
    );

endmodule

// File: tb/wd_strobe_watchdog_bench.sv
module wd_strobe_watchdog_bench;

    localparam int PS = 5;
    localparam int PM = 9;
    localparam int PL = 13;

    // {sel[15:14], strobe after tick[13:8], ticks[7:0]}
    localparam logic [15:0] VEC [12] = '{
        {2'd0, 6'd0,  8'd5},
        {2'd0, 6'd0,  8'd4},
        {2'd1, 6'd0,  8'd9},
        {2'd2, 6'd0,  8'd13},
        {2'd3, 6'd0,  8'd9},
        {2'd3, 6'd0,  8'd8},
        {2'd0, 6'd3,  8'd10},
        {2'd1, 6'd8,  8'd20},
        {2'd2, 6'd12, 8'd30},
        {2'd0, 6'd5,  8'd10},
        {2'd0, 6'd4,  8'd12},
        {2'd1, 6'd1,  8'd12}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       strb = 1'b1;
    logic [1:0] sel = 2'd0;
    logic       ra = 1'b0;
    logic       timeout;

    int checks = 0;
    int fails = 0;
    int total = 0;
    int tick_no = 0;
    int first = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wd_strobe_watchdog #(.P_SHORT(PS), .P_MID(PM), .P_LONG(PL)) u_wd_strobe_watchdog (
        .clk          (clk),
        .rst          (rst),
        .tick_ms_i    (tick),
        .strobe_i     (strb),
        .period_sel_i (sel),
        .rst_active_i (ra),
        .timeout_o    (timeout)
    );

    always @(negedge clk) if (timeout) total++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input int s);
        case (s)
            0: return PS;
            2: return PL;
            default: return PM;
        endcase
    endfunction

    function automatic int expect_first(input int lim, input int sa, input int n);
        int t;
        t = (sa == 0 || sa >= lim) ? lim : sa + lim;
        return (t <= n) ? t : 0;
    endfunction

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        tick_no++;
        @(negedge clk) tick = 1'b0;
        if (timeout && first == 0) first = tick_no;
        @(negedge clk);
    endtask

    task automatic strobe_pulse();
        @(negedge clk) strb = 1'b0;
        @(negedge clk) strb = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic recover();
        @(negedge clk) ra = 1'b1;
        repeat (3) @(negedge clk);
        ra = 1'b0;
        repeat (2) @(negedge clk);
        tick_no = 0;
        first = 0;
    endtask

    task automatic ticks_until(input int max, output int at);
        first = 0;
        tick_no = 0;
        for (int i = 0; i < max && first == 0; i++) do_tick();
        at = first;
    endtask

    initial begin
        int base;
        int at;
        int e;
        repeat (4) @(negedge clk);
        chk("R1 timeout low in reset", int'(timeout), 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk) base = total;
        // R4 + R1: free-running from zero without any strobe
        ticks_until(20, at);
        chk("R4 no-strobe expiry tick", at, PS);
        // R8 + R7: expired state ignores strobes and stays quiet
        strobe_pulse();
        for (int i = 0; i < 2 * PS; i++) do_tick();
        @(posedge clk);
        chk("R8 pulse cycles after expiry", total - base, 1);

        // Vector table
        foreach (VEC[k]) begin
            int s;
            int sa;
            int n;
            s  = int'(VEC[k][15:14]);
            sa = int'(VEC[k][13:8]);
            n  = int'(VEC[k][7:0]);
            sel = VEC[k][15:14];
            recover();
            @(posedge clk) base = total;
            for (int i = 1; i <= n; i++) begin
                do_tick();
                if (i == sa) strobe_pulse();
            end
            @(posedge clk);
            e = expect_first(period_of(s), sa, n);
            chk("R2/R5/R9 first timeout tick", first, e);
            chk("R8 pulse count", total - base, (e != 0) ? 1 : 0);
        end

        // R7: no timeout while reset-active is held, ticks notwithstanding
        sel = 2'd0;
        @(negedge clk) ra = 1'b1;
        strb = 1'b0;
        @(posedge clk) base = total;
        for (int i = 0; i < 3 * PS; i++) do_tick();
        @(posedge clk);
        chk("R7 quiet under reset-active", total - base, 0);
        @(negedge clk) ra = 1'b0;
        repeat (2) @(negedge clk);
        // R3: a steady low level and then a rising edge do not service
        first = 0;
        tick_no = 0;
        for (int i = 0; i < PS - 2; i++) do_tick();
        @(negedge clk) strb = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4 && first == 0; i++) do_tick();
        chk("R3 rise does not restart", first, PS);

        // R6: select change mid-count waits for the next restart
        sel = 2'd0;
        recover();
        do_tick();
        do_tick();
        sel = 2'd2;
        ticks_until(20, at);
        chk("R6 old period kept", at + 2, PS);
        recover();
        ticks_until(20, at);
        chk("R6 new period after restart", at, PL);

        // R10: strobe edge and tick acted on in the same cycle
        sel = 2'd0;
        recover();
        for (int i = 0; i < 3; i++) do_tick();
        @(negedge clk) strb = 1'b0;
        @(negedge clk) strb = 1'b1;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (2) @(negedge clk);
        ticks_until(20, at);
        chk("R10 restart wins over tick", at, PS);

        // R11: no ticks, no progress
        recover();
        @(posedge clk) base = total;
        repeat (200) @(negedge clk);
        @(posedge clk);
        chk("R11 idle without ticks", total - base, 0);
        ticks_until(20, at);
        chk("R11 count starts at zero", at, PS);

        // R1: reset mid-count clears the count
        do_tick();
        recover();
        do_tick();
        do_tick();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 timeout low in reset", int'(timeout), 0);
        rst = 1'b0;
        ticks_until(20, at);
        chk("R1 count cleared by reset", at, PS);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule